// File: doc/BRIEF.md
# Bit-Serial Systolic Montgomery Multiplier

The block computes the Montgomery product `x·y·2^-w mod m` of two w-bit operands against an odd w-bit modulus. The y operand, the modulus and their precomputed sum sit in a one-dimensional array of bit cells. The array is cut into equal stages. The x operand enters one bit per iteration, least significant bit first, from a shift register. A first-cell unit derives the quotient bit `q` from the running sum and the current x bit. That bit then travels up the stages alongside the x bit. Each cell adds 0, y, m or m+y, chosen by the pair (x bit, q). The sum is registered and then read back shifted right by one position. A stage therefore needs the lowest stored sum bit of the stage above it, and each stage updates at most once every two clocks. The iterations move through the stages as a diagonal wavefront.

A 2-bit part select, captured with the start strobe, runs the computation on the lower stages only, on the upper stages only, or on the whole array. In the two split modes the operands are taken from the low bits of the input ports and the result is returned in the low bits of `result`. After the last iteration a top-cell unit holds the two extra sum bits. A single-cycle reduction step subtracts m once if the value is not below m. `done` then pulses for one clock, and the result stays registered until the next accepted start.

The controller is an explicit state machine. ST_IDLE goes to ST_FEED when start is accepted. ST_FEED issues one x bit every second clock and goes to ST_DRAIN after the w-th bit. ST_DRAIN goes to ST_REDUCE when the top cell finishes iteration w. ST_REDUCE goes to ST_FINISH, which drives `done`, and ST_FINISH returns to ST_IDLE.

Top module: `mont_sys_mul`

## Requirements
- R1: With `part_sel` 11 (full width w = TOTAL_BITS), x < m, y < m and m odd, `result` equals x·y·2^-w mod m when `done` is high.
- R2: With `part_sel` 01, only the lower LOW_BITS = STAGES_LOW·(TOTAL_BITS/STAGES) bits are used. The operands are the low LOW_BITS bits of the ports, the result is x·y·2^-LOW_BITS mod m in the low bits, and all higher result bits are 0.
- R3: With `part_sel` 10, only the upper TOTAL_BITS−LOW_BITS bits are used. The operands are taken from the low bits of the ports, the result is returned in the low bits, and all higher result bits are 0. `part_sel` 00 behaves as 11.
- R4: The final conditional subtraction leaves `result` strictly below the active modulus, including operands that push the pre-reduction value to m or above.
- R5: `done` is high for exactly one clock per accepted start. `result` holds its value from that clock until the next accepted start.
- R6: `done` is high in the cycle after the (2·w + P)-th rising edge that follows the edge accepting start. P is the number of active stages.
- R7: A start pulse, and any operand or part-select change, while the block is busy is ignored. The running computation and its result are unaffected.
- R8: A synchronous active-high reset clears the state, so that `done` is 0 and `result` is 0.
- R9: Each stage performs at most one update in any two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| part_sel | input | 2 | Active part: 01 lower, 10 upper, 11 or 00 full |
| x_in | input | TOTAL_BITS | Operand x, fed serially LSB first |
| y_in | input | TOTAL_BITS | Operand y |
| m_in | input | TOTAL_BITS | Odd modulus |
| result | output | TOTAL_BITS | Reduced Montgomery product |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random odd moduli with the top bit set and random operands below them are run in all three part modes. Any error in carry or shift-in wiring between stages, or in the routing of the first and last stage, shows up there as a wrong product. Directed cases cover x = 0 (result 0), x = y = 1 (a bare 2^-w), x = y = m−1 with an all-ones modulus and a tiny modulus of 3. The last two force the final subtraction path apart from the no-subtract path. Measuring the start-to-done distance per mode separates the full-array wavefront from the split ones, and a start injected mid-run with different operands shows whether busy-time inputs leak into the computation.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FEED,
        ST_DRAIN,
        ST_REDUCE,
        ST_FINISH
    } mm_state_e;

    localparam logic [1:0] PART_LOWER = 2'b01;
    localparam logic [1:0] PART_UPPER = 2'b10;

endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] nact,
    input  logic          last_en,
    output logic          clr,
    output logic          go,
    output logic          reduce,
    output logic          done,
    output logic          busy
);

    mm_state_e     state_q, state_d;
    logic          phase_q;
    logic [CW-1:0] feed_cnt_q;
    logic [CW-1:0] tail_cnt_q;
    logic          feed_last;
    logic          tail_last;

    assign feed_last = (feed_cnt_q == nact - 1'b1);
    assign tail_last = (tail_cnt_q == nact - 1'b1);

    // state register and iteration counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            phase_q    <= 1'b0;
            feed_cnt_q <= '0;
            tail_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (clr) begin
                phase_q    <= 1'b0;
                feed_cnt_q <= '0;
                tail_cnt_q <= '0;
            end else begin
                if (state_q == ST_FEED) phase_q <= ~phase_q;
                if (go)      feed_cnt_q <= feed_cnt_q + 1'b1;
                if (last_en) tail_cnt_q <= tail_cnt_q + 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        go      = 1'b0;
        reduce  = 1'b0;
        done    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    clr     = 1'b1;
                    state_d = ST_FEED;
                end
            end
            ST_FEED: begin
                go = ~phase_q;
                if (go && feed_last) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (last_en && tail_last) state_d = ST_REDUCE;
            end
            ST_REDUCE: begin
                reduce  = 1'b1;
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
    AST_FEED_SPACED: assert property (@(posedge clk) disable iff (rst) go |=> !go); // R9

endmodule

// File: rtl/mm_stage.sv
module mm_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en_i,
    input  logic         x_i,
    input  logic         q_i,
    input  logic         cin_i,
    input  logic         shin_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] my_i,
    output logic [W-1:0] s_o,
    output logic         cout_o,
    output logic         en_o,
    output logic         x_o,
    output logic         q_o
);

    logic [W-1:0] t_prev;
    logic [W-1:0] addend;
    logic [W:0]   sum;

    // previous sum read back one bit lower, top bit from the stage above
    assign t_prev = {shin_i, s_o[W-1:1]};

    always_comb begin
        unique case ({x_i, q_i})
            2'b00:   addend = '0;
            2'b01:   addend = m_i;
            2'b10:   addend = y_i;
            default: addend = my_i;
        endcase
    end

    assign sum = {1'b0, t_prev} + {1'b0, addend} + {{W{1'b0}}, cin_i};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            s_o    <= '0;
            cout_o <= 1'b0;
            en_o   <= 1'b0;
            x_o    <= 1'b0;
            q_o    <= 1'b0;
        end else begin
            en_o <= en_i;
            x_o  <= x_i;
            q_o  <= q_i;
            if (en_i) {cout_o, s_o} <= sum;
        end
    end

    AST_STAGE_RATE: assert property (@(posedge clk) disable iff (rst) en_i |=> !en_i); // R9

endmodule

// File: rtl/mm_last_cell.sv
module mm_last_cell (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en_i,
    input  logic       x_i,
    input  logic       q_i,
    input  logic       cin_i,
    input  logic       my_top_i,
    output logic [1:0] top_o
);

    logic [1:0] sum;

    // bit w of the previous value plus bit w of the addend plus carry
    assign sum = {1'b0, top_o[1]} + {1'b0, x_i & q_i & my_top_i} + {1'b0, cin_i};

    always_ff @(posedge clk) begin
        if (rst || clr) top_o <= '0;
        else if (en_i)  top_o <= sum;
    end

endmodule

// File: rtl/mont_sys_mul.sv
module mont_sys_mul
    import mm_pkg::*;
#(
    parameter int TOTAL_BITS = 1536,
    parameter int STAGES     = 96,
    parameter int STAGES_LOW = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [1:0]            part_sel,
    input  logic [TOTAL_BITS-1:0] x_in,
    input  logic [TOTAL_BITS-1:0] y_in,
    input  logic [TOTAL_BITS-1:0] m_in,
    output logic [TOTAL_BITS-1:0] result,
    output logic                  done
);

    localparam int N         = TOTAL_BITS;
    localparam int W         = TOTAL_BITS / STAGES;
    localparam int LOW_BITS  = STAGES_LOW * W;
    localparam int HIGH_BITS = N - LOW_BITS;
    localparam int CW        = $clog2(N + 1);
    localparam int SW        = $clog2(STAGES);

    logic clr, go, reduce, busy, last_en;

    // ---------------- operand capture ----------------
    logic [CW-1:0] wid_d, wid_q, off_d, off_q;
    logic [N-1:0]  mask_d, mask_q;
    logic [N-1:0]  x_m, y_m, m_m;
    logic [N:0]    my_sum;
    logic [N-1:0]  y_al, m_al, my_al, x_sh, m_act_q;
    logic          my_top_q;
    logic [1:0]    part_q;

    always_comb begin
        unique case (part_sel)
            PART_LOWER: begin wid_d = CW'(LOW_BITS);  off_d = '0; end
            PART_UPPER: begin wid_d = CW'(HIGH_BITS); off_d = CW'(LOW_BITS); end
            default:    begin wid_d = CW'(N);         off_d = '0; end
        endcase
        mask_d = {N{1'b1}} >> (N - int'(wid_d));
        x_m    = x_in & mask_d;
        y_m    = y_in & mask_d;
        m_m    = m_in & mask_d;
        my_sum = {1'b0, y_m} + {1'b0, m_m};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q   <= 2'b11;
            wid_q    <= CW'(N);
            off_q    <= '0;
            mask_q   <= '0;
            y_al     <= '0;
            m_al     <= '0;
            my_al    <= '0;
            my_top_q <= 1'b0;
            m_act_q  <= '0;
            x_sh     <= '0;
        end else if (clr) begin
            part_q   <= part_sel;
            wid_q    <= wid_d;
            off_q    <= off_d;
            mask_q   <= mask_d;
            y_al     <= y_m << off_d;
            m_al     <= m_m << off_d;
            my_al    <= (my_sum[N-1:0] & mask_d) << off_d;
            my_top_q <= my_sum[wid_d];
            m_act_q  <= m_m;
            x_sh     <= x_m;
        end else if (go) begin
            x_sh <= x_sh >> 1;
        end
    end

    // ---------------- stage chain ----------------
    logic [SW-1:0] first_idx, last_idx;
    assign first_idx = (part_q == PART_UPPER) ? SW'(STAGES_LOW) : '0;
    assign last_idx  = (part_q == PART_LOWER) ? SW'(STAGES_LOW - 1) : SW'(STAGES - 1);

    logic [STAGES-1:0][W-1:0] s_w;
    logic [STAGES-1:0]        cout_w, en_w, xo_w, qo_w;
    logic [1:0]               top_w;
    logic                     q_first;

    // first cell: quotient bit from bit 0 of the running value and x·y0
    assign q_first = s_w[first_idx][1] ^ (x_sh[0] & y_al[int'(first_idx) * W]);

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic is_first, is_last, active;
        logic en_k, x_k, q_k, cin_k, shin_k;

        assign is_first = (first_idx == SW'(k));
        assign is_last  = (last_idx == SW'(k));
        assign active   = (SW'(k) >= first_idx) && (SW'(k) <= last_idx);

        if (k == 0) begin : g_bottom
            assign en_k  = active & is_first & go;
            assign x_k   = x_sh[0];
            assign q_k   = q_first;
            assign cin_k = 1'b0;
        end else begin : g_chain
            assign en_k  = active & (is_first ? go : en_w[k-1]);
            assign x_k   = is_first ? x_sh[0] : xo_w[k-1];
            assign q_k   = is_first ? q_first : qo_w[k-1];
            assign cin_k = is_first ? 1'b0 : cout_w[k-1];
        end

        if (k == STAGES - 1) begin : g_top
            assign shin_k = top_w[0];
        end else begin : g_mid
            assign shin_k = is_last ? top_w[0] : s_w[k+1][0];
        end

        mm_stage #(.W(W)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .en_i   (en_k),
            .x_i    (x_k),
            .q_i    (q_k),
            .cin_i  (cin_k),
            .shin_i (shin_k),
            .y_i    (y_al[k*W +: W]),
            .m_i    (m_al[k*W +: W]),
            .my_i   (my_al[k*W +: W]),
            .s_o    (s_w[k]),
            .cout_o (cout_w[k]),
            .en_o   (en_w[k]),
            .x_o    (xo_w[k]),
            .q_o    (qo_w[k])
        );
    end

    assign last_en = en_w[last_idx];

    mm_last_cell u_last (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .en_i     (last_en),
        .x_i      (xo_w[last_idx]),
        .q_i      (qo_w[last_idx]),
        .cin_i    (cout_w[last_idx]),
        .my_top_i (my_top_q),
        .top_o    (top_w)
    );

    mm_ctrl #(.CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .nact    (wid_q),
        .last_en (last_en),
        .clr     (clr),
        .go      (go),
        .reduce  (reduce),
        .done    (done),
        .busy    (busy)
    );

    // ---------------- final reduction ----------------
    logic [N-1:0] s_act;
    logic [N+1:0] full_v;
    logic [N:0]   t_fin, t_sub;
    logic [N-1:0] res_d;

    always_comb begin
        s_act  = (s_w >> off_q) & mask_q;
        full_v = {2'b00, s_act} | ({{N{1'b0}}, top_w} << wid_q);
        t_fin  = full_v[N+1:1];
        t_sub  = t_fin - {1'b0, m_act_q};
        res_d  = (t_fin >= {1'b0, m_act_q}) ? t_sub[N-1:0] : t_fin[N-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)         result <= '0;
        else if (reduce) result <= res_d;
    end

    AST_RES_BELOW_MOD: assert property (@(posedge clk) disable iff (rst) done |-> (result < m_act_q)); // R4
    AST_RES_IN_PART:   assert property (@(posedge clk) disable iff (rst) done |-> ((result & ~mask_q) == '0)); // R2
    AST_BUSY_HOLDS:    assert property (@(posedge clk) disable iff (rst) busy |=> $stable(m_act_q)); // R7
    AST_RES_HELD:      assert property (@(posedge clk) disable iff (rst) !reduce |=> $stable(result)); // R5

endmodule

// File: tb/sim_mont_sys_mul.sv
module sim_mont_sys_mul;

    localparam int N  = 64;
    localparam int S  = 4;
    localparam int SL = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   part_sel = 2'b11;
    logic [N-1:0] x_in = '0, y_in = '0, m_in = '0;
    logic [N-1:0] result;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mont_sys_mul #(.TOTAL_BITS(N), .STAGES(S), .STAGES_LOW(SL)) u0 (
        .clk(clk), .rst(rst), .start(start), .part_sel(part_sel),
        .x_in(x_in), .y_in(y_in), .m_in(m_in), .result(result), .done(done)
    );

    function automatic logic [N-1:0] ref_mont(logic [N-1:0] x, logic [N-1:0] y, logic [N-1:0] m, int w);
        logic [N+1:0] t = '0;
        for (int i = 0; i < w; i++) begin
            if (x[i]) t = t + {2'b00, y};
            if (t[0]) t = t + {2'b00, m};
            t = t >> 1;
        end
        if (t >= {2'b00, m}) t = t - {2'b00, m};
        return t[N-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one multiplication; optional disturbing start while busy
    task automatic run(input logic [1:0] sel, input logic [N-1:0] x, input logic [N-1:0] y,
                       input logic [N-1:0] m, input bit disturb, input string req);
        int w, p, cnt;
        logic [N-1:0] msk, exp, held;
        w = (sel == 2'b01 || sel == 2'b10) ? 32 : 64;
        p = (sel == 2'b01 || sel == 2'b10) ? 2 : 4;
        msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
        exp = ref_mont(x & msk, y & msk, m & msk, w);
        @(negedge clk);
        part_sel = sel; x_in = x; y_in = y; m_in = m; start = 1'b1;
        @(posedge clk);
        cnt = 0;
        forever begin
            @(negedge clk);
            start = disturb && (cnt == 10);
            if (disturb && cnt == 10) begin
                part_sel = 2'b01; x_in = ~x; y_in = 64'd5; m_in = 64'd7;
            end
            if (done || cnt > 400) break;
            @(posedge clk);
            cnt++;
        end
        check(result == exp, {req, " product"}, result, exp);
        check(cnt == 2 * w + p, "R6 R9 latency", 64'(cnt), 64'(2 * w + p));
        check((result & ~msk) == '0, "R2 R3 high bits clear", result & ~msk, '0);
        check(result < (m & msk) || (m & msk) == '0, "R4 below modulus", result, m & msk);
        held = result;
        @(negedge clk);
        check(done == 1'b0, "R5 done single cycle", 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        check(result == held, "R5 result held", result, held);
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [N-1:0] m, x, y;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8 reset done", 64'(done), 64'd0);
        check(result == '0, "R8 reset result", result, '0);

        // directed corners
        run(2'b11, 64'd0, 64'h1234_5678_9abc_def0, 64'hffff_ffff_ffff_ffc5, 1'b0, "R1 x zero");
        run(2'b11, 64'd1, 64'd1, 64'hc000_0000_0000_0001, 1'b0, "R1 inverse radix");
        run(2'b11, 64'hffff_ffff_ffff_fffe, 64'hffff_ffff_ffff_fffe, 64'hffff_ffff_ffff_ffff, 1'b0, "R4 max operands");
        run(2'b11, 64'd2, 64'd2, 64'd3, 1'b0, "R4 small modulus");
        run(2'b00, 64'd77, 64'd91, 64'h8000_0000_0000_0065, 1'b0, "R3 select 00 full");

        // random, all parts
        for (int i = 0; i < 6; i++) begin
            m = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
            x = {$urandom, $urandom} % m;
            y = {$urandom, $urandom} % m;
            run(2'b11, x, y, m, 1'b0, "R1 random full");
        end
        for (int i = 0; i < 4; i++) begin
            m = {32'($urandom), $urandom | 32'h8000_0001};
            x = 64'($urandom % m[31:0]) | ({32'($urandom), 32'd0});
            y = 64'($urandom % m[31:0]);
            run(2'b01, x, y, m, 1'b0, "R2 random lower");
        end
        for (int i = 0; i < 4; i++) begin
            m = {32'($urandom), $urandom | 32'h8000_0001};
            x = 64'($urandom % m[31:0]);
            y = 64'($urandom % m[31:0]) | ({32'($urandom), 32'd0});
            run(2'b10, x, y, m, 1'b0, "R3 random upper");
        end

        // start while busy must be ignored
        m = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
        run(2'b11, {$urandom, $urandom} % m, {$urandom, $urandom} % m, m, 1'b1, "R7 busy start");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule